// File: doc/BRIEF.md
# Write-Start Hardware Inhibit Qualifier

This block sits between the external control pins of an electrically erasable memory and its internal write sequencer. It decides whether a write request on the pins may launch a write cycle. It runs on a synchronous clock. It takes a digital supply-good flag from an analog comparator outside the block, plus active-low chip-select, write-enable and output-enable pins. It produces a single-cycle write-start pulse.

Four separate inhibits are merged into that pulse:

- **Supply-low lockout:** no write may start while the supply flag is low.
- **Power-on hold-off:** a hold-off timer runs after the supply flag rises, and writes stay blocked until it expires.
- **Pin-state inhibit:** output-enable held low blocks writes.
- **Minimum-width filter:** chip-select and write-enable must both be low together for a minimum number of clocks, so short glitches on either strobe never start a write.

Every pin first passes through a two-flop synchroniser.

Top module: `wr_inhibit_qual`

## Requirements
- R1: While and after reset, with no qualified request, `wr_start` is low.
- R2: While the synchronised supply-good flag is low, `wr_start` never pulses.
- R3: After the synchronised supply-good flag rises, `wr_start` stays low until the flag has been high for POR_CYCLES consecutive clocks.
- R4: Any clock with the synchronised supply-good flag low restarts the power-on hold-off from zero.
- R5: While synchronised `oe_n` is low (including with `cs_n` or `we_n` high), no write starts.
- R6: A joint low period of `cs_n` and `we_n` shorter than FILT_CYCLES synchronised clocks never starts a write; a period of exactly FILT_CYCLES does.
- R7: When the block is powered-up and `oe_n` is high, `wr_start` rises on the (FILT_CYCLES+2)-th rising clock edge, counting the first edge that samples both strobes low as edge 1.
- R8: Each joint low period yields exactly one `wr_start` pulse, one clock wide. Another pulse requires `cs_n` and `we_n` to be sampled high together first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_ok | input | 1 | Supply-above-threshold flag, asynchronous |
| cs_n | input | 1 | Chip select pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| wr_start | output | 1 | One-clock write-start pulse |

## Verification
The bench builds the block with POR_CYCLES=40 and FILT_CYCLES=3. A hold-off of 40 clocks lets one run try writes inside the hold-off, just after it ends, and after a one-clock supply dip, all within a few hundred cycles. A three-clock filter makes the boundary concrete: a two-clock glitch must be rejected and a three-clock low accepted. A queue-based model of the synchronised pins predicts `wr_start` on every clock.

// File: rtl/wr_inhibit_qual.sv
module wr_inhibit_qual #(
  parameter int POR_CYCLES  = 1250000,
  parameter int FILT_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_ok,
  input  logic cs_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_start
);
  localparam int PW = $clog2(POR_CYCLES + 1);
  localparam int FW = $clog2(FILT_CYCLES) + 1;
  localparam logic [PW-1:0] PMAX = PW'(POR_CYCLES);
  localparam logic [FW-1:0] FMAX = FW'(FILT_CYCLES - 1);

  logic [3:0] s1, s2;
  logic [PW-1:0] por_cnt;
  logic [FW-1:0] lo_cnt;
  logic fired;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 4'b0111;
      s2 <= 4'b0111;
    end else begin
      s1 <= {vcc_ok, cs_n, we_n, oe_n};
      s2 <= s1;
    end

  wire vcc_s  = s2[3];
  wire cs_s   = s2[2];
  wire we_s   = s2[1];
  wire oe_s   = s2[0];
  wire act    = !cs_s && !we_s && oe_s;
  wire powered = vcc_s && (por_cnt == PMAX);
  wire qual   = act && powered && (lo_cnt == FMAX) && !fired;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            por_cnt <= '0;
    else if (!vcc_s)       por_cnt <= '0;
    else if (por_cnt != PMAX) por_cnt <= por_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            lo_cnt <= '0;
    else if (!act)         lo_cnt <= '0;
    else if (lo_cnt != FMAX) lo_cnt <= lo_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fired    <= 1'b0;
      wr_start <= 1'b0;
    end else begin
      wr_start <= qual;
      if (qual)              fired <= 1'b1;
      else if (cs_s && we_s) fired <= 1'b0;
    end

  p_unpowered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_s |=> !wr_start);
  p_holdoff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (por_cnt != PMAX) |=> !wr_start);
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_s |=> (por_cnt == '0));
  p_oe_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_s |=> !wr_start);
  p_strobes_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(!cs_s && !we_s));
  p_one_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
endmodule

// File: tb/test_wr_inhibit_qual.sv
module test_wr_inhibit_qual;
  localparam int POR  = 40;
  localparam int FILT = 3;

  logic clk = 0, rst_n = 0;
  logic vcc_ok = 0, cs_n = 1, we_n = 1, oe_n = 1;
  logic wr_start;
  int total = 0, bad = 0, pulses = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  wr_inhibit_qual #(.POR_CYCLES(POR), .FILT_CYCLES(FILT)) i_wr_inhibit_qual (
    .clk(clk), .rst_n(rst_n), .vcc_ok(vcc_ok), .cs_n(cs_n), .we_n(we_n),
    .oe_n(oe_n), .wr_start(wr_start));

  // reference model: pins seen through a two-sample delay queue
  logic [3:0] hist[$];
  int vage, lrun;
  bit mfired, exp_ws;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {4'b0111, 4'b0111};
      vage = 0; lrun = 0; mfired = 0; exp_ws = 0;
    end else begin
      logic [3:0] s;
      bit a, nxt;
      s = hist[1];
      a = !s[2] && !s[1] && s[0];
      nxt = a && s[3] && (vage >= POR) && (lrun >= FILT - 1) && !mfired;
      vage = s[3] ? ((vage < POR) ? vage + 1 : POR) : 0;
      lrun = a ? lrun + 1 : 0;
      if (nxt) mfired = 1;
      else if (s[2] && s[1]) mfired = 0;
      hist.push_front({vcc_ok, cs_n, we_n, oe_n});
      void'(hist.pop_back());
      exp_ws = nxt;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    total++;
    if (wr_start !== exp_ws) begin
      bad++;
      $display("FAIL %s: wr_start=%b expected=%b at %0t", cur_req, wr_start, exp_ws, $time);
    end
    if (wr_start) pulses++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic drv(input logic v, input logic c, input logic w, input logic o);
    @(negedge clk);
    vcc_ok = v; cs_n = c; we_n = w; oe_n = o;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_check(input int p0, input int expn, input string req);
    check(pulses - p0 == expn, req, pulses - p0, expn);
  endtask

  initial begin
    int p0, lat;
    run(4);
    check(wr_start === 1'b0, "R1", wr_start, 0);
    rst_n = 1;
    run(3);
    check(wr_start === 1'b0, "R1", wr_start, 0);

    cur_req = "R2"; p0 = pulses;
    drv(0, 0, 0, 1); run(20); drv(0, 1, 1, 1); run(5);
    count_check(p0, 0, "R2");

    cur_req = "R3"; p0 = pulses;
    drv(1, 1, 1, 1); run(10);
    drv(1, 0, 0, 1); run(10); drv(1, 1, 1, 1);
    count_check(p0, 0, "R3");
    run(40);

    cur_req = "R7"; p0 = pulses;
    drv(1, 0, 0, 1);
    lat = 0;
    while (!wr_start && lat < 30) begin @(negedge clk); lat++; end
    check(lat == FILT + 2, "R7", lat, FILT + 2);

    cur_req = "R8";
    run(20);
    drv(1, 1, 0, 1); run(3); drv(1, 0, 0, 1); run(10);
    count_check(p0, 1, "R8");
    drv(1, 1, 1, 1); run(3); drv(1, 0, 0, 1); run(10); drv(1, 1, 1, 1); run(4);
    count_check(p0, 2, "R8");

    cur_req = "R6"; p0 = pulses;
    drv(1, 0, 1, 1); drv(1, 0, 0, 1); run(1); drv(1, 0, 1, 1); run(2);
    drv(1, 1, 1, 1); run(6);
    count_check(p0, 0, "R6");
    drv(1, 0, 0, 1); run(2); drv(1, 1, 1, 1); run(8);
    count_check(p0, 1, "R6");

    cur_req = "R5"; p0 = pulses;
    drv(1, 0, 0, 0); run(12);
    drv(1, 1, 0, 0); run(6); drv(1, 0, 1, 0); run(6); drv(1, 1, 1, 1); run(4);
    count_check(p0, 0, "R5");

    cur_req = "R4"; p0 = pulses;
    drv(0, 1, 1, 1); drv(1, 1, 1, 1); run(25);
    drv(1, 0, 0, 1); run(12); drv(1, 1, 1, 1); run(4);
    count_check(p0, 0, "R4");
    run(30);
    drv(1, 0, 0, 1); run(10); drv(1, 1, 1, 1); run(4);
    count_check(p0, 1, "R4");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule